// File: doc/BRIEF.md
# IR carrier modulation generator

This block produces the square-wave carrier that an infrared transmitter switches onto its LED during mark symbols. Each carrier period has an active (high) phase and an inactive (low) phase. Both are measured in ticks of a selectable timebase, and each length is programmed as a tick count minus one. There are four timebases: every system clock cycle, a crystal strobe divided by three, a 1 µs prescaled tick, and a 10 µs prescaled tick. A typical setup gives a 38 kHz carrier at 50 % duty. A one-cycle pulse marks the end of every carrier period, and the symbol sequencer counts these pulses to time its marks.

A gate from the sequencer decides whether the carrier reaches the output. A rising gate restarts the period at the start of the active phase, so every mark begins with a full high phase. During configuration a force-high control holds the output high and keeps the counter idle. Software clears that control and then sets enable. Both outputs are registered.

The controller has four states. `ST_OFF` holds the counter at zero while enable is low. `ST_FORCE` holds the counter at zero while force-high is set. `ST_MARK` counts the active phase and `ST_SPACE` counts the inactive phase. The transitions are:
- any state to `ST_FORCE` while force-high is set;
- any state to `ST_OFF` while enable is low and force-high is clear;
- `ST_OFF` or `ST_FORCE` to `ST_MARK` once the block is enabled and not forced;
- `ST_MARK` to `ST_SPACE` when the active count expires;
- `ST_SPACE` to `ST_MARK` when the inactive count expires, which is the period wrap;
- `ST_SPACE` or `ST_MARK` to `ST_MARK` on a gate rise, which is the restart.

Top module: `irc_carrier_gen`

## Requirements
- R1: `cfg_src_i` selects the tick. 0 gives one tick per system clock, 1 gives one tick per three `xtal_stb_i` strobes, 2 gives one tick per `CYC_PER_US` cycles, and 3 gives one tick per `CYC_PER_US*SLOW_DIV` cycles.
- R2: In steady state the carrier stays high for `cfg_counts_i[2*CNT_W-1:CNT_W]`+1 ticks per period.
- R3: In steady state the carrier stays low for `cfg_counts_i[CNT_W-1:0]`+1 ticks per period.
- R4: `period_end_o` is a one-cycle pulse, given exactly once per period. It is high in the same cycle in which the carrier starts the next active phase.
- R5: The block samples `cfg_counts_i` only at a period start. A change made within a period leaves that period's high and low lengths unchanged.
- R6: While `cfg_enable_i` is 0 and force-high is clear, `carrier_o` and `period_end_o` are 0 from the next cycle on. After enable, the first high phase is a full `hi`+1 ticks counted from zero.
- R7: While `cfg_force_high_i` is 1, `carrier_o` is 1 from the next cycle on, whatever enable and gate are, and `period_end_o` stays 0.
- R8: While `gate_i` is 0 and force-high is clear, `carrier_o` is 0 from the next cycle on. The period counting and the `period_end_o` pulses carry on.
- R9: On a rising `gate_i` while the block is enabled, `carrier_o` is 1 in the next cycle and the active phase starts over with its full length.
- R10: During and immediately after reset, `carrier_o` and `period_end_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_stb_i | input | 1 | One-cycle strobe per crystal clock cycle, synchronous to clk |
| cfg_enable_i | input | 1 | Transmitter enable; 0 holds the carrier counter at zero |
| cfg_force_high_i | input | 1 | Forces the output high during configuration |
| cfg_src_i | input | 2 | Tick source selection (see R1) |
| cfg_counts_i | input | 2*CNT_W | Upper field: high ticks minus one; lower field: low ticks minus one |
| gate_i | input | 1 | Carrier gate from the symbol sequencer |
| carrier_o | output | 1 | Registered carrier waveform |
| period_end_o | output | 1 | One-cycle pulse at each carrier period wrap |

## Verification
The bench sets `CYC_PER_US` to 4 and leaves `SLOW_DIV` at 10. With these values a 1 µs tick is 4 cycles and a 10 µs tick is 40 cycles. A crystal strobe on every second cycle gives a divided tick of 6 cycles. All four sources therefore complete several periods within a short run, and high and low lengths can be measured exactly in clock cycles. Running the system-clock source with counts of zero drives the carrier at its shortest period of two cycles. In that setting, back-to-back wraps and gate restarts can fall on any phase.

// File: rtl/irc_pkg.sv
package irc_pkg;

    typedef enum logic [1:0] {
        SRC_SYS   = 2'd0,
        SRC_XTAL3 = 2'd1,
        SRC_US    = 2'd2,
        SRC_US10  = 2'd3
    } irc_src_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_FORCE,
        ST_MARK,
        ST_SPACE
    } irc_state_e;

    localparam int XTAL_DIV = 3;

endpackage

// File: rtl/irc_tick_gen.sv
module irc_tick_gen
    import irc_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int SLOW_DIV   = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xtal_stb_i,
    input  logic [1:0] src_i,
    output logic       tick_o
);

    localparam int US_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam int SL_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [US_W-1:0] us_cnt;
    logic [SL_W-1:0] sl_cnt;
    logic [1:0]      x_cnt;
    logic            us_wrap;
    logic            sl_wrap;
    logic            x_wrap;
    logic            tick_d;

    assign us_wrap = (us_cnt == US_W'(CYC_PER_US - 1));
    assign sl_wrap = us_wrap && (sl_cnt == SL_W'(SLOW_DIV - 1));
    assign x_wrap  = xtal_stb_i && (x_cnt == 2'(XTAL_DIV - 1));

    always_comb begin
        unique case (src_i)
            SRC_SYS:   tick_d = 1'b1;
            SRC_XTAL3: tick_d = x_wrap;
            SRC_US:    tick_d = us_wrap;
            SRC_US10:  tick_d = sl_wrap;
            default:   tick_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_cnt <= '0;
            sl_cnt <= '0;
            x_cnt  <= '0;
            tick_o <= 1'b0;
        end else begin
            us_cnt <= us_wrap ? '0 : us_cnt + 1'b1;
            if (us_wrap) begin
                sl_cnt <= sl_wrap ? '0 : sl_cnt + 1'b1;
            end
            if (xtal_stb_i) begin
                x_cnt <= x_wrap ? '0 : x_cnt + 1'b1;
            end
            tick_o <= tick_d;
        end
    end

endmodule

// File: rtl/irc_phase_fsm.sv
module irc_phase_fsm
    import irc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic             force_i,
    input  logic             gate_i,
    input  logic             gate_rise_i,
    input  logic [CNT_W-1:0] mark_last_i,
    input  logic [CNT_W-1:0] space_last_i,
    output logic             load_o,
    output logic             carrier_o,
    output logic             period_end_o
);

    irc_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             wrap;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        wrap    = 1'b0;
        load_o  = 1'b0;
        if (force_i) begin
            state_n = ST_FORCE;
            cnt_n   = '0;
        end else if (!enable_i) begin
            state_n = ST_OFF;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ST_OFF, ST_FORCE: begin
                    state_n = ST_MARK;
                    cnt_n   = '0;
                    load_o  = 1'b1;
                end
                ST_MARK: begin
                    if (gate_rise_i) begin
                        cnt_n  = '0;
                        load_o = 1'b1;
                    end else if (tick_i) begin
                        if (cnt_q == mark_last_i) begin
                            state_n = ST_SPACE;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                ST_SPACE: begin
                    if (gate_rise_i) begin
                        state_n = ST_MARK;
                        cnt_n   = '0;
                        load_o  = 1'b1;
                    end else if (tick_i) begin
                        if (cnt_q == space_last_i) begin
                            state_n = ST_MARK;
                            cnt_n   = '0;
                            load_o  = 1'b1;
                            wrap    = 1'b1;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carrier_o    <= 1'b0;
            period_end_o <= 1'b0;
        end else begin
            carrier_o    <= force_i || ((state_n == ST_MARK) && gate_i);
            period_end_o <= wrap;
        end
    end

endmodule

// File: rtl/irc_carrier_gen.sv
module irc_carrier_gen
    import irc_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int SLOW_DIV   = 10,
    parameter int CNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xtal_stb_i,
    input  logic               cfg_enable_i,
    input  logic               cfg_force_high_i,
    input  logic [1:0]         cfg_src_i,
    input  logic [2*CNT_W-1:0] cfg_counts_i,
    input  logic               gate_i,
    output logic               carrier_o,
    output logic               period_end_o
);

    logic             tick;
    logic             gate_q;
    logic             gate_rise;
    logic             load;
    logic [CNT_W-1:0] mark_last_q;
    logic [CNT_W-1:0] space_last_q;

    assign gate_rise = gate_i && !gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q       <= 1'b0;
            mark_last_q  <= '0;
            space_last_q <= '0;
        end else begin
            gate_q <= gate_i;
            if (load) begin
                mark_last_q  <= cfg_counts_i[2*CNT_W-1:CNT_W];
                space_last_q <= cfg_counts_i[CNT_W-1:0];
            end
        end
    end

    irc_tick_gen #(
        .CYC_PER_US (CYC_PER_US),
        .SLOW_DIV   (SLOW_DIV)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .xtal_stb_i (xtal_stb_i),
        .src_i      (cfg_src_i),
        .tick_o     (tick)
    );

    irc_phase_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .enable_i     (cfg_enable_i),
        .force_i      (cfg_force_high_i),
        .gate_i       (gate_i),
        .gate_rise_i  (gate_rise),
        .mark_last_i  (mark_last_q),
        .space_last_i (space_last_q),
        .load_o       (load),
        .carrier_o    (carrier_o),
        .period_end_o (period_end_o)
    );

endmodule

// File: rtl/irc_carrier_chk.sv
module irc_carrier_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable_i,
    input logic cfg_force_high_i,
    input logic gate_i,
    input logic carrier_o,
    input logic period_end_o
);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable_i && !cfg_force_high_i) |=> (!carrier_o && !period_end_o)); // R6

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_force_high_i |=> (carrier_o && !period_end_o)); // R7

    AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i && !cfg_force_high_i) |=> !carrier_o); // R8

    AST_GATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_i) && cfg_enable_i && !cfg_force_high_i) |=> carrier_o); // R9

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_o |=> !period_end_o); // R4

endmodule

bind irc_carrier_gen irc_carrier_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_enable_i     (cfg_enable_i),
    .cfg_force_high_i (cfg_force_high_i),
    .gate_i           (gate_i),
    .carrier_o        (carrier_o),
    .period_end_o     (period_end_o)
);

// File: tb/tb_irc_carrier_gen.sv
`timescale 1ns/1ps
module tb_irc_carrier_gen;

    localparam int CPU  = 4;
    localparam int SLOW = 10;
    localparam int CW   = 16;
    localparam int XGAP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xtal_stb = 1'b0;
    logic          en = 1'b0;
    logic          frc = 1'b0;
    logic [1:0]    src = 2'd0;
    logic [2*CW-1:0] counts = '0;
    logic          gate = 1'b0;
    logic          carrier;
    logic          pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int xph = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        xph = (xph == XGAP - 1) ? 0 : xph + 1;
        xtal_stb = (xph == 0);
    end

    irc_carrier_gen #(.CYC_PER_US(CPU), .SLOW_DIV(SLOW), .CNT_W(CW)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .xtal_stb_i       (xtal_stb),
        .cfg_enable_i     (en),
        .cfg_force_high_i (frc),
        .cfg_src_i        (src),
        .cfg_counts_i     (counts),
        .gate_i           (gate),
        .carrier_o        (carrier),
        .period_end_o     (pend)
    );

    function automatic int tick_cycles(int sel);
        case (sel)
            0: return 1;
            1: return 3 * XGAP;
            2: return CPU;
            default: return CPU * SLOW;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic p;
        p = carrier;
        forever begin
            @(negedge clk);
            if (!p && carrier) break;
            p = carrier;
        end
    endtask

    // assumes the current sample is the first high sample of a period
    task automatic measure(output int h, output int l, output int np);
        h = 1; l = 0; np = 0;
        forever begin
            @(negedge clk);
            np += int'(pend);
            if (carrier && l == 0) h++;
            else if (!carrier) l++;
            else break;
        end
    endtask

    task automatic start(int sel, int hi, int lo);
        @(negedge clk);
        en = 1'b0; frc = 1'b0;
        @(negedge clk);
        src = 2'(sel);
        counts = {CW'(hi), CW'(lo)};
        gate = 1'b1;
        en = 1'b1;
    endtask

    task automatic trial(int sel, int hi, int lo);
        int h, l, np;
        start(sel, hi, lo);
        wait_rise();
        wait_rise();
        measure(h, l, np);
        check($sformatf("R1 R2 high src=%0d", sel), h, (hi + 1) * tick_cycles(sel));
        check($sformatf("R1 R3 low src=%0d", sel), l, (lo + 1) * tick_cycles(sel));
        check("R4 pulse per period", np, 1);
        check("R4 pulse at rise", int'(pend), 1);
    endtask

    initial begin
        int h, l, np, bad, k;
        void'($urandom(32'd2718));

        repeat (3) @(negedge clk);
        check("R10 carrier in reset", int'(carrier), 0);
        check("R10 pulse in reset", int'(pend), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 carrier after reset", int'(carrier), 0);
        check("R10 pulse after reset", int'(pend), 0);

        // every tick source, directed
        for (int s = 0; s < 4; s++) trial(s, 1, 2);
        trial(0, 0, 0);
        trial(0, 7, 2);
        // random mix
        for (int i = 0; i < 10; i++) trial(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));

        // R5: change counts mid period
        start(0, 4, 4);
        wait_rise();
        wait_rise();
        counts = {CW'(1), CW'(1)};
        measure(h, l, np);
        check("R5 old high kept", h, 5);
        check("R5 old low kept", l, 5);
        measure(h, l, np);
        check("R5 new high", h, 2);
        check("R5 new low", l, 2);

        // R6: disabled is quiet, restart from zero
        en = 1'b0;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (carrier || pend) bad++;
        end
        check("R6 quiet while disabled", bad, 0);
        counts = {CW'(3), CW'(2)};
        en = 1'b1;
        @(negedge clk);
        check("R6 first sample high", int'(carrier), 1);
        measure(h, l, np);
        check("R6 first high full", h, 4);
        check("R6 first low", l, 3);

        // R7: force high overrides gate and enable
        frc = 1'b1; gate = 1'b0;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (!carrier || pend) bad++;
        end
        check("R7 forced high", bad, 0);
        en = 1'b0;
        bad = 0;
        repeat (10) begin
            @(negedge clk);
            if (!carrier || pend) bad++;
        end
        check("R7 forced high while disabled", bad, 0);
        frc = 1'b0;

        // R8: gate low silences output, pulses continue
        start(0, 1, 1);
        repeat (10) @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
        bad = 0; np = 0;
        repeat (20) begin
            @(negedge clk);
            if (carrier) bad++;
            np += int'(pend);
        end
        check("R8 carrier low with gate low", bad, 0);
        check("R8 pulses continue", np, 5);

        // R9: gate rise restarts active phase
        start(0, 5, 5);
        repeat (8) begin
            k = int'($urandom_range(1, 20));
            gate = 1'b0;
            repeat (k) @(negedge clk);
            gate = 1'b1;
            @(negedge clk);
            check("R9 high after gate rise", int'(carrier), 1);
            measure(h, l, np);
            check("R9 full high after restart", h, 6);
            check("R9 low after restart", l, 6);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule